// File: doc/BRIEF.md
# Saturating Lane-Sum Unit

This block folds a wide vector of signed 16-bit lanes into one saturated 16-bit scalar. It is meant for the tail of a fixed-point dot product, where the per-lane products are already formed and only the horizontal sum is left. Each lane is sign-extended into a narrow wrapping accumulator of 16 + log2(lanes) bits. The accumulator is truncated back to that width after every addition. The final total is then packed into 16 bits with saturation at both ends.

The unit accepts a vector through a valid/ready handshake and works through the lanes one per cycle, starting at lane 0. It registers the packed result and holds it with a valid flag until the consumer takes it. Only then does it raise its ready flag again.

The controller is a four-state machine:
- `ST_IDLE`: waits for a vector. Its only transition is *accept* (`in_valid` high) to `ST_ACCUM`.
- `ST_ACCUM`: adds one lane per cycle. It stays there (*step*) until the last lane, then takes *last_lane* to `ST_PACK`.
- `ST_PACK`: writes the saturated result register and takes *packed* to `ST_HOLD`.
- `ST_HOLD`: presents the result. It stays there (*stall*) while `out_ready` is low and takes *consume* back to `ST_IDLE`.

Top module: `sat_lane_sum`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Lane k of `in_vec` occupies bits [16k+15:16k] and is read as a signed two's-complement value, so the top lane is sign-extended like every other lane.
- R3: Lanes are summed in a 21-bit accumulator (16 value bits plus 5 carry bits) that is truncated to 21 bits after each addition. With 32 lanes the total is therefore exact, including the extreme of all lanes at -32768.
- R4: A total greater than 32767 produces `out_data` = 0x7FFF. For example, all lanes at 32767 give 0x7FFF, and 32767 + 1 gives 0x7FFF.
- R5: A total less than -32768 produces `out_data` = 0x8000. For example, all lanes at -32768 give 0x8000, and -32768 + -1 gives 0x8000.
- R6: A total in [-32768, 32767] appears on `out_data` as its 16-bit two's-complement value. For example, lanes [100, -50, 0...] give 0x0032, and 32 lanes of -1 give 0xFFE0.
- R7: `out_valid` rises exactly one cycle after the cycle that adds the last lane. That is 33 clock edges after the accepting edge, and the first cycle the result can be observed is the 34th half-period sample after acceptance.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R9: `in_ready` is 0 from the accepting edge until the result has been consumed. A vector offered on `in_valid` during that time is not captured and does not affect the pending result.
- R10: On an edge where `out_valid` and `out_ready` are both 1, the result is consumed. In the next cycle `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A vector is offered on `in_vec` |
| in_ready | output | 1 | Unit is idle and will take a vector on this edge |
| in_vec | input | 512 | 32 signed 16-bit lanes, lane 0 in the low bits |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_valid | output | 1 | `out_data` holds a finished result |
| out_data | output | 16 | Saturated 16-bit sum |

## Verification
The assertions check four behaviours on every cycle:
- the exact 33-edge latency from acceptance to `out_valid`;
- a stalled result staying put;
- ready dropping after an accept and never coinciding with a valid result;
- the clean return to idle after consumption.

The arithmetic cannot be seen by any per-cycle property on the ports, so only the bench's scenarios can show it. Those scenarios cover the saturation thresholds on both sides (exactly 32767, one above, exactly -32768, one below), sign extension of the top lane, lane placement, and the all-maximum and all-minimum vectors. Whether a vector offered while busy is truly ignored is also shown only by the scenario that compares the delivered result against the first vector's sum.

// File: rtl/sat_lane_sum_pkg.sv
package sat_lane_sum_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_PACK  = 2'd2,
        ST_HOLD  = 2'd3
    } sls_state_e;

endpackage

// File: rtl/sls_lane_ext.sv
// Sign-extends one lane into the accumulator width; the width itself is the mask.
module sls_lane_ext #(
    parameter int LANE_W = 16,
    parameter int ACC_W  = 21
) (
    input  logic [LANE_W-1:0] lane_i,
    output logic [ACC_W-1:0]  ext_o
);
    localparam int PAD_W = ACC_W - LANE_W;

    always_comb begin
        ext_o = {{PAD_W{lane_i[LANE_W-1]}}, lane_i};
    end
endmodule

// File: rtl/sls_sat_pack.sv
// Reads the accumulator as signed and packs it into OUT_W bits with saturation.
module sls_sat_pack #(
    parameter int ACC_W = 21,
    parameter int OUT_W = 16
) (
    input  logic [ACC_W-1:0] acc_i,
    output logic [OUT_W-1:0] res_o
);
    localparam int POS_I = (1 << (OUT_W - 1)) - 1;
    localparam int NEG_I = -(1 << (OUT_W - 1));
    localparam logic signed [ACC_W-1:0] POS_LIM = POS_I[ACC_W-1:0];
    localparam logic signed [ACC_W-1:0] NEG_LIM = NEG_I[ACC_W-1:0];

    logic signed [ACC_W-1:0] acc_s;
    logic                    over_hi;
    logic                    under_lo;

    always_comb begin
        acc_s    = acc_i;
        over_hi  = acc_s > POS_LIM;
        under_lo = acc_s < NEG_LIM;
        if (over_hi) begin
            res_o = {1'b0, {(OUT_W-1){1'b1}}};
        end else if (under_lo) begin
            res_o = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            res_o = acc_i[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/sat_lane_sum.sv
module sat_lane_sum
    import sat_lane_sum_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int LANE_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*LANE_W-1:0] in_vec,
    input  logic                    out_ready,
    output logic                    out_valid,
    output logic [LANE_W-1:0]       out_data
);
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int ACC_W = LANE_W + IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LANES - 1);
    localparam int LAT_W = $clog2(LANES + 4) + 1;
    localparam logic [LAT_W-1:0] LAT_EXP = LAT_W'(LANES + 1);

    sls_state_e state_q, state_d;

    logic [LANES*LANE_W-1:0] vec_q;
    logic [IDX_W-1:0]        idx_q;
    logic [ACC_W-1:0]        acc_q;
    logic [LANE_W-1:0]       res_q;
    logic [LANE_W-1:0]       lane_w [LANES];
    logic [ACC_W-1:0]        ext_w;
    logic [LANE_W-1:0]       pack_w;
    logic                    accept_w;
    logic                    consume_w;

    // Lane slicing of the captured vector.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_w[g] = vec_q[g*LANE_W +: LANE_W];
    end

    sls_lane_ext #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_ext (
        .lane_i (lane_w[idx_q]),
        .ext_o  (ext_w)
    );

    sls_sat_pack #(.ACC_W(ACC_W), .OUT_W(LANE_W)) u_pack (
        .acc_i (acc_q),
        .res_o (pack_w)
    );

    assign accept_w  = (state_q == ST_IDLE) && in_valid;
    assign consume_w = (state_q == ST_HOLD) && out_ready;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid)          state_d = ST_ACCUM;
            ST_ACCUM: if (idx_q == LAST_IDX) state_d = ST_PACK;
            ST_PACK:                         state_d = ST_HOLD;
            ST_HOLD:  if (out_ready)         state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            idx_q <= '0;
            acc_q <= '0;
            res_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        vec_q <= in_vec;
                        idx_q <= '0;
                        acc_q <= '0;
                    end
                end
                ST_ACCUM: begin
                    acc_q <= acc_q + ext_w;   // wraps at ACC_W bits
                    idx_q <= idx_q + 1'b1;
                end
                ST_PACK:  res_q <= pack_w;
                ST_HOLD:  ;
                default:  ;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        in_ready  = (state_q == ST_IDLE);
        out_valid = (state_q == ST_HOLD);
        out_data  = res_q;
    end

    // Latency observer for the R7 check.
    logic [LAT_W-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                lat_q <= '0;
        else if (accept_w)                         lat_q <= '0;
        else if (!out_valid && state_q != ST_IDLE) lat_q <= lat_q + 1'b1;
    end

    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> lat_q == LAT_EXP);

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);

    assert_ready_excl_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    assert_idle_after_consume_R10: assert property (@(posedge clk) disable iff (!rst_n)
        consume_w |=> !out_valid && in_ready);

endmodule

// File: tb/sat_lane_sum_tb_top.sv
`timescale 1ns/1ps
module sat_lane_sum_tb_top;
    localparam int LANES  = 32;
    localparam int LANE_W = 16;
    localparam int VW     = LANES * LANE_W;
    localparam int LAT_SAMPLES = LANES + 2;   // R7: 33 edges, seen at 34th negedge sample

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [VW-1:0] in_vec = '0;
    logic          out_ready = 1'b0;
    logic          out_valid;
    logic [15:0]   out_data;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;   // 250 MHz

    sat_lane_sum #(.LANES(LANES), .LANE_W(LANE_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_vec    (in_vec),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] fill_all(input int v);
        logic [VW-1:0] r;
        for (int k = 0; k < LANES; k++) r[k*LANE_W +: LANE_W] = 16'(v);
        return r;
    endfunction

    // Offers a vector, measures latency, checks result, consumes it (R10 checked).
    task automatic run_vec(input logic [VW-1:0] v, input int exp, input string req);
        int cyc;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_vec   = v;
        @(negedge clk);
        in_valid = 1'b0;
        cyc = 1;
        while (!out_valid && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk({req, " R7 latency"}, cyc, LAT_SAMPLES);
        chk(req, int'(out_data), exp);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R10 valid after consume", int'(out_valid), 0);
        chk("R10 ready after consume", int'(in_ready), 1);
    endtask

    task automatic t_reset();
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 out_valid", int'(out_valid), 0);
    endtask

    task automatic t_saturation();
        logic [VW-1:0] v;
        run_vec(fill_all(32767), 16'h7FFF, "R4 all max");
        run_vec(fill_all(-32768), 16'h8000, "R5 R3 all min");
        v = '0; v[15:0] = 16'(32767); v[31:16] = 16'(1);
        run_vec(v, 16'h7FFF, "R4 one above");
        v = '0; v[15:0] = 16'(-32768); v[31:16] = 16'(-1);
        run_vec(v, 16'h8000, "R5 one below");
    endtask

    task automatic t_passthrough();
        logic [VW-1:0] v;
        v = '0; v[15:0] = 16'(100); v[31:16] = 16'(-50);
        run_vec(v, 16'h0032, "R6 mixed");
        run_vec(fill_all(-1), 16'hFFE0, "R6 all minus one");
        v = '0; v[15:0] = 16'(32767);
        run_vec(v, 16'h7FFF, "R6 exact top");
        v = '0; v[20*16 +: 16] = 16'(-32768);
        run_vec(v, 16'h8000, "R6 exact bottom");
    endtask

    task automatic t_lanes();
        logic [VW-1:0] v;
        v = '0; v[31*16 +: 16] = 16'(-3);
        run_vec(v, 16'hFFFD, "R2 top lane sign");
        v = '0; v[5*16 +: 16] = 16'(7); v[30*16 +: 16] = 16'(1000);
        run_vec(v, 1007, "R2 lane placement");
    endtask

    task automatic t_stall_and_busy();
        logic [VW-1:0] v;
        v = '0; v[15:0] = 16'(100); v[31:16] = 16'(-50);
        @(negedge clk);
        in_valid = 1'b1;
        in_vec   = v;
        @(negedge clk);
        in_vec = fill_all(32767);      // offered while busy, must be ignored
        chk("R9 busy ready", int'(in_ready), 0);
        while (!out_valid) @(negedge clk);
        in_valid = 1'b0;
        chk("R9 ignored vector", int'(out_data), 16'h0032);
        for (int i = 0; i < 10; i++) @(negedge clk);
        chk("R8 valid held", int'(out_valid), 1);
        chk("R8 data held", int'(out_data), 16'h0032);
        chk("R9 ready while held", int'(in_ready), 0);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        chk("R10 consume", int'(out_valid), 0);
        @(negedge clk);
        chk("R9 no capture after consume", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_saturation();
        t_passthrough();
        t_lanes();
        t_stall_and_busy();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule